// File: doc/BRIEF.md
# Logic Slice with Side-by-Side Multiplexers

This block models one configurable logic slice made of two halves, F and G. Each half has a 4-input lookup table, a dedicated 4:1 multiplexer wired to the same four data inputs, and a D flip-flop. A static configuration picks, per half, whether the table or the multiplexer result becomes that half's combinational output. It also picks whether the flip-flop loads that result or the half's own bypass pin.

Both multiplexers take their select lines from the two bypass pins, with the Y pin as the high bit and the X pin as the low bit. The slice therefore gains multiplexer capacity without any extra input pins. The cost is that while either multiplexer is active, the bypass pins are busy as selects and cannot feed the flip-flops. A configuration that asks for both raises a conflict flag, and the affected flip-flop falls back to its combinational result.

Top module: `logic_slice_mux`

## Requirements
- R1: With multiplexer mode off for a half, its combinational output equals bit `idx` of that half's 16-bit truth word, where `idx` is the 4-bit data input with bit 3 as the MSB.
- R2: With multiplexer mode on for a half, its combinational output equals data input bit `{byp_y, byp_x}`: select 00 picks bit 0 and select 11 picks bit 3.
- R3: The two halves choose table or multiplexer independently of each other. When both use the multiplexer, they use the same select pair.
- R4: When `rst` is 0 and `ce` is 1, a flip-flop output takes its D value one clock edge later.
- R5: When `rst` is 0 and `ce` is 0, the flip-flop outputs hold their values across the clock edge.
- R6: When `rst` is 1 at a clock edge, both flip-flop outputs become 0, whatever the value of `ce`. Reset takes priority over `ce`.
- R7: When a half's pin-load bit is set and no half has multiplexer mode on, the F flip-flop loads `byp_x` and the G flip-flop loads `byp_y`.
- R8: `cfg_conflict` is 1 exactly when at least one pin-load bit is set and at least one multiplexer-mode bit is set.
- R9: While `cfg_conflict` is 1, a half whose pin-load bit is set loads its own combinational output instead of its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of both flip-flops |
| ce | input | 1 | Clock enable of both flip-flops |
| cfg_truth_f | input | 16 | Truth word of the F table |
| cfg_truth_g | input | 16 | Truth word of the G table |
| cfg_mux_mode | input | 2 | Per half (bit 0 = F, bit 1 = G): 1 selects the multiplexer result |
| cfg_ff_pin | input | 2 | Per half: 1 requests that the flip-flop load the bypass pin |
| lut_in_f | input | 4 | Data inputs of half F |
| lut_in_g | input | 4 | Data inputs of half G |
| byp_x | input | 1 | Bypass pin X: F flip-flop source and select bit 0 |
| byp_y | input | 1 | Bypass pin Y: G flip-flop source and select bit 1 |
| comb_f | output | 1 | Combinational result of half F |
| comb_g | output | 1 | Combinational result of half G |
| q_f | output | 1 | Registered output of half F |
| q_g | output | 1 | Registered output of half G |
| cfg_conflict | output | 1 | Pins requested both as selects and as flip-flop data |

## Verification
A wrong table index or select order shows on `comb_f` or `comb_g` in the same cycle the inputs change, so each pattern is compared before the next one is driven. A flip-flop that loads the wrong source, ignores `ce`, or misses reset shows on `q_f` or `q_g` one edge later. Because the bench carries its model register forward, the error keeps showing until a later load overwrites it. A conflict rule decoded wrongly shows at once on `cfg_conflict`, and on the flip-flop outputs one edge later, as a pin value where the combinational value was expected.

// File: rtl/slice_mux_pkg.sv
package slice_mux_pkg;

    localparam int LUT_IN    = 4;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int SEL_W     = 2;
    localparam int HALVES    = 2;

    typedef enum logic {
        SRC_TABLE = 1'b0,
        SRC_MUX   = 1'b1
    } comb_src_e;

    typedef struct packed {
        logic [LUT_DEPTH-1:0] truth;
        comb_src_e            src;
        logic                 ff_pin;
    } half_cfg_t;

    function automatic logic table_eval(input logic [LUT_DEPTH-1:0] t,
                                        input logic [LUT_IN-1:0]    a);
        return t[a];
    endfunction

    function automatic logic mux_pick(input logic [LUT_IN-1:0] d,
                                      input logic [SEL_W-1:0]  s);
        return d[s];
    endfunction

endpackage

// File: rtl/slice_half_comb.sv
module slice_half_comb
    import slice_mux_pkg::*;
(
    input  half_cfg_t            cfg,
    input  logic [LUT_IN-1:0]    din,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 pin,
    input  logic                 pins_busy,
    output logic                 comb,
    output logic                 d
);

    logic table_bit;
    logic mux_bit;

    always_comb begin
        table_bit = table_eval(cfg.truth, din);
        mux_bit   = mux_pick(din, sel);
        comb      = (cfg.src == SRC_MUX) ? mux_bit : table_bit;
        d         = (cfg.ff_pin && !pins_busy) ? pin : comb;
    end

endmodule

// File: rtl/slice_ff.sv
module slice_ff (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ce)
            q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == 1'b0)); // R6
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q)); // R5
    AST_CE_LOAD: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q == $past(d))); // R4

endmodule

// File: rtl/logic_slice_mux.sv
module logic_slice_mux
    import slice_mux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [LUT_DEPTH-1:0] cfg_truth_f,
    input  logic [LUT_DEPTH-1:0] cfg_truth_g,
    input  logic [HALVES-1:0]    cfg_mux_mode,
    input  logic [HALVES-1:0]    cfg_ff_pin,
    input  logic [LUT_IN-1:0]    lut_in_f,
    input  logic [LUT_IN-1:0]    lut_in_g,
    input  logic                 byp_x,
    input  logic                 byp_y,
    output logic                 comb_f,
    output logic                 comb_g,
    output logic                 q_f,
    output logic                 q_g,
    output logic                 cfg_conflict
);

    half_cfg_t             cfg_v  [HALVES];
    logic [LUT_IN-1:0]     din_v  [HALVES];
    logic [HALVES-1:0]     pin_v;
    logic [HALVES-1:0]     comb_v;
    logic [HALVES-1:0]     d_v;
    logic [HALVES-1:0]     q_v;
    logic [SEL_W-1:0]      sel;
    logic                  pins_busy;

    assign sel       = {byp_y, byp_x};
    assign pin_v     = {byp_y, byp_x};
    assign pins_busy = |cfg_mux_mode;

    always_comb begin
        cfg_v[0].truth  = cfg_truth_f;
        cfg_v[0].src    = comb_src_e'(cfg_mux_mode[0]);
        cfg_v[0].ff_pin = cfg_ff_pin[0];
        cfg_v[1].truth  = cfg_truth_g;
        cfg_v[1].src    = comb_src_e'(cfg_mux_mode[1]);
        cfg_v[1].ff_pin = cfg_ff_pin[1];
        din_v[0]        = lut_in_f;
        din_v[1]        = lut_in_g;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        slice_half_comb u_comb (
            .cfg       (cfg_v[h]),
            .din       (din_v[h]),
            .sel       (sel),
            .pin       (pin_v[h]),
            .pins_busy (pins_busy),
            .comb      (comb_v[h]),
            .d         (d_v[h])
        );

        slice_ff u_ff (
            .clk (clk),
            .rst (rst),
            .ce  (ce),
            .d   (d_v[h]),
            .q   (q_v[h])
        );

        AST_CONFLICT_TAKES_COMB: assert property (@(posedge clk) disable iff (rst)
            cfg_conflict |-> (d_v[h] == comb_v[h])); // R9
        AST_PIN_FEEDS_D: assert property (@(posedge clk) disable iff (rst)
            (!cfg_conflict && cfg_ff_pin[h]) |-> (d_v[h] == pin_v[h])); // R7
    end

    assign cfg_conflict = (|cfg_ff_pin) && pins_busy;
    assign comb_f       = comb_v[0];
    assign comb_g       = comb_v[1];
    assign q_f          = q_v[0];
    assign q_g          = q_v[1];

endmodule

// File: tb/test_logic_slice_mux.sv
module test_logic_slice_mux;

    logic        clk = 1'b0;
    logic        rst, ce;
    logic [15:0] cfg_truth_f, cfg_truth_g;
    logic [1:0]  cfg_mux_mode, cfg_ff_pin;
    logic [3:0]  lut_in_f, lut_in_g;
    logic        byp_x, byp_y;
    logic        comb_f, comb_g, q_f, q_g, cfg_conflict;

    logic_slice_mux i_logic_slice_mux (
        .clk(clk), .rst(rst), .ce(ce),
        .cfg_truth_f(cfg_truth_f), .cfg_truth_g(cfg_truth_g),
        .cfg_mux_mode(cfg_mux_mode), .cfg_ff_pin(cfg_ff_pin),
        .lut_in_f(lut_in_f), .lut_in_g(lut_in_g),
        .byp_x(byp_x), .byp_y(byp_y),
        .comb_f(comb_f), .comb_g(comb_g), .q_f(q_f), .q_g(q_g),
        .cfg_conflict(cfg_conflict)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic cf, cg, qf, qg, err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    logic  m_qf = 1'b0, m_qg = 1'b0;
    bit    finished = 0;

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e,
                        input logic [15:0] tf, input logic [15:0] tg,
                        input logic [1:0] mm, input logic [1:0] fp,
                        input logic [3:0] inf, input logic [3:0] ing,
                        input logic bx, input logic by, input string tag);
        exp_t x;
        logic df, dg;
        @(negedge clk);
        rst = r; ce = e; cfg_truth_f = tf; cfg_truth_g = tg;
        cfg_mux_mode = mm; cfg_ff_pin = fp; lut_in_f = inf; lut_in_g = ing;
        byp_x = bx; byp_y = by;
        x.cf  = mm[0] ? inf[{by, bx}] : tf[inf];
        x.cg  = mm[1] ? ing[{by, bx}] : tg[ing];
        x.err = (|fp) && (|mm);
        df = (fp[0] && !(|mm)) ? bx : x.cf;
        dg = (fp[1] && !(|mm)) ? by : x.cg;
        if (r) begin m_qf = 1'b0; m_qg = 1'b0; end
        else if (e) begin m_qf = df; m_qg = dg; end
        x.qf = m_qf;
        x.qg = m_qg;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // monitor: compares after each rising edge, before the next drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check1(t, "comb_f", comb_f, x.cf);
                check1(t, "comb_g", comb_g, x.cg);
                check1(t, "q_f", q_f, x.qf);
                check1(t, "q_g", q_g, x.qg);
                check1(t, "cfg_conflict", cfg_conflict, x.err);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state, R6
        step(1, 1, 16'h0000, 16'h0000, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, "R6_reset");
        step(1, 0, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 4'h3, 4'h5, 1, 1, "R6_reset_ce0");
        // R1 table mode with load, R4
        for (int i = 0; i < 16; i++)
            step(0, 1, 16'hA5C3, 16'h8001, 2'b00, 2'b00, 4'(i), 4'(15 - i), 0, 0, "R1_R4_table");
        // R2 multiplexer on F only; G stays a table, R3
        for (int s = 0; s < 4; s++)
            step(0, 1, 16'h0000, 16'h6996, 2'b01, 2'b00, 4'b0101, 4'(s * 5), s[0], s[1], "R2_R3_muxF");
        for (int s = 0; s < 4; s++)
            step(0, 1, 16'hFFFF, 16'h0000, 2'b01, 2'b00, 4'(1 << s), 4'h7, s[0], s[1], "R2_onehot");
        // R3 both multiplexers share the select
        for (int s = 0; s < 4; s++)
            step(0, 1, 16'hFFFF, 16'hFFFF, 2'b11, 2'b00, 4'b1100, 4'b0011, s[0], s[1], "R3_shared");
        // R5 hold
        step(0, 1, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 4'h1, 4'h1, 0, 0, "R4_set_ones");
        step(0, 0, 16'h0000, 16'h0000, 2'b00, 2'b00, 4'h1, 4'h1, 0, 0, "R5_hold");
        step(0, 0, 16'h0000, 16'h0000, 2'b00, 2'b11, 4'h2, 4'h2, 0, 0, "R5_hold_pin");
        // R7 bypass load, R8 no conflict
        step(0, 1, 16'h0000, 16'hFFFF, 2'b00, 2'b11, 4'h0, 4'h0, 1, 0, "R7_R8_pins");
        step(0, 1, 16'hFFFF, 16'h0000, 2'b00, 2'b11, 4'h0, 4'h0, 0, 1, "R7_pins_b");
        step(0, 1, 16'hFFFF, 16'h0000, 2'b00, 2'b01, 4'h0, 4'h0, 0, 1, "R7_pin_f_only");
        // R8 and R9 conflicts
        step(0, 1, 16'h0000, 16'h0000, 2'b01, 2'b10, 4'b0000, 4'h0, 1, 1, "R8_R9_conflict_g");
        step(0, 1, 16'h0000, 16'h0000, 2'b10, 2'b01, 4'h0, 4'b1000, 1, 1, "R8_R9_conflict_f");
        step(0, 1, 16'hFFFF, 16'hFFFF, 2'b11, 2'b11, 4'b0001, 4'b0001, 0, 0, "R8_R9_both");
        // R6 reset priority over a low ce
        step(0, 1, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 4'h9, 4'h9, 0, 0, "R4_set_again");
        step(1, 0, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 4'h9, 4'h9, 0, 0, "R6_priority");
        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule